// File: doc/BRIEF.md
# Synchronous SRAM Byte-Write and Output Mode Controller

This block is the control logic at the data port of a synchronous SRAM. Each rising clock edge it samples an all-lane write override, a byte write enable and one active-low enable per byte lane. From these it decides whether the cycle is a write or a read. A write yields a one-cycle set of per-lane write strobes towards the array. A read raises a read request, and the data the array returns goes out on the data bus.

A static mode input picks how read data reaches the bus. In flow-through mode the array data passes straight to the bus in the same cycle as the read request. In pipelined mode the data is first captured in an output register and so reaches the bus one cycle later. The output enable follows whichever timing is selected. The bus is released during every write cycle. A sampled power-down input turns the cycle into standby: no strobes, no read, and the bus released.

A lane-count parameter lets a narrow configuration leave its upper lanes unbuilt. Their enables are then ignored and their outputs stay off. Lane i always covers data bits [i*LANE_W +: LANE_W], and bit i of each lane vector belongs to lane i.

Top module: `sram_port_ctrl`

## Requirements
- R1: When `gw_n` is sampled low and `zz` low, the next cycle has `wr_stb` high on every used lane, whatever `bw_n` and `be_n` are.
- R2: When `gw_n` is sampled high, `bw_n` low and `zz` low, and at least one used `be_n` bit is low, the next cycle has `wr_stb[i]` high exactly for the used lanes i whose `be_n[i]` was 0 (any combination).
- R3: When `gw_n` is sampled high with `zz` low, and either `bw_n` is high or every used `be_n` bit is high, the next cycle has `rd_en` high and `wr_stb` all zero; `rd_en` and `wr_stb` are never high together.
- R4: Strobes last one cycle per sampled write: a write followed by a read gives a strobe pulse of exactly one cycle.
- R5: With `ft_n` = 0 (flow-through), `dq_oe` is high on all used lanes in exactly the cycles where `rd_en` is high, and `dq_o` equals `rd_data` in those cycles.
- R6: With `ft_n` = 1 (pipelined), `dq_oe` is high on all used lanes in the cycle after an `rd_en` cycle, and `dq_o` then carries the `rd_data` present during the `rd_en` cycle.
- R7: During reads every used lane is driven, whatever the `be_n` bits were; `dq_oe` is either all zero or all used lanes.
- R8: `dq_oe` is zero in every cycle where any `wr_stb` bit is high, including a pipelined read result that would fall into a write cycle.
- R9: When `zz` is sampled high, the next cycle has no strobes, no `rd_en` and `dq_oe` all zero.
- R10: With `USED_LANES` below `NUM_LANES`, the upper `be_n` bits are ignored (also in the read decision), and the upper `wr_stb` and `dq_oe` bits are never asserted.
- R11: While `rst_n` is low, `wr_stb`, `rd_en` and `dq_oe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; controls sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| gw_n | input | 1 | Active-low write of all used lanes |
| bw_n | input | 1 | Active-low qualifier for the per-lane enables |
| be_n | input | NUM_LANES | Active-low per-lane write enables, bit i for lane i |
| ft_n | input | 1 | Output mode: 0 flow-through, 1 pipelined |
| zz | input | 1 | Power-down: 1 standby, 0 active |
| rd_data | input | LANE_W*NUM_LANES | Read data from the array, valid during an `rd_en` cycle |
| wr_stb | output | NUM_LANES | Per-lane write strobes to the array |
| rd_en | output | 1 | Read request to the array |
| dq_o | output | LANE_W*NUM_LANES | Data towards the bus pads |
| dq_oe | output | NUM_LANES | Per-lane output enable for the bus pads |

## Verification
On every cycle the assertions check the write and read decode one cycle after sampling. They also check that strobes and read never coincide, that the bus is released under strobes and in standby, and that the output enable is all-or-nothing and never reaches unused lanes. They tie the output enable to the read request with the lag of the selected mode. The data content on the bus is shown only by the bench scenarios. These compare `dq_o` against bench-held array data in both modes, drop a pipelined read into a following write, and apply wide-lane enables to the narrow instance.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/sram_ctl_decode.sv
module sram_ctl_decode
  import sram_ctl_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int USED_LANES = 4
) (
  input  logic                 gw_n,
  input  logic                 bw_n,
  input  logic [NUM_LANES-1:0] be_n,
  input  logic                 zz,
  output op_e                  op,
  output logic [NUM_LANES-1:0] strb
);

  localparam logic [NUM_LANES-1:0] USED_MASK =
    NUM_LANES'((64'd1 << USED_LANES) - 64'd1);

  logic [NUM_LANES-1:0] lane_sel;

  // per-lane requests, only for lanes that exist
  always_comb begin
    lane_sel = ~be_n & USED_MASK & {NUM_LANES{~bw_n}};
  end

  always_comb begin
    op   = OP_READ;
    strb = '0;
    if (zz) begin
      op = OP_IDLE;
    end else if (!gw_n) begin
      op   = OP_WRITE;
      strb = USED_MASK;
    end else if (|lane_sel) begin
      op   = OP_WRITE;
      strb = lane_sel;
    end
  end

endmodule

// File: rtl/sram_ctl_cmd_reg.sv
module sram_ctl_cmd_reg
  import sram_ctl_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  op_e                  op_d,
  input  logic [NUM_LANES-1:0] strb_d,
  input  logic                 zz_d,
  output logic [NUM_LANES-1:0] wr_q,
  output logic                 rd_q,
  output logic                 zz_q
);

  logic [NUM_LANES-1:0] wr_nxt;
  logic                 rd_nxt;

  always_comb begin
    wr_nxt = (op_d == OP_WRITE) ? strb_d : '0;
    rd_nxt = (op_d == OP_READ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= 1'b0;
      zz_q <= 1'b0;
    end else begin
      wr_q <= wr_nxt;
      rd_q <= rd_nxt;
      zz_q <= zz_d;
    end
  end

endmodule

// File: rtl/sram_ctl_out_stage.sv
module sram_ctl_out_stage #(
  parameter int LANE_W     = 9,
  parameter int NUM_LANES  = 4,
  parameter int USED_LANES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ft_n,
  input  logic                        rd_q,
  input  logic                        wr_any,
  input  logic                        zz_q,
  input  logic [LANE_W*NUM_LANES-1:0] rd_data,
  output logic [LANE_W*NUM_LANES-1:0] dq_o,
  output logic [NUM_LANES-1:0]        dq_oe
);

  localparam int DATA_W = LANE_W * NUM_LANES;

  logic              pipe_vld;
  logic              pipe_vld_nxt;
  logic [DATA_W-1:0] pipe_data;
  logic [DATA_W-1:0] pipe_data_nxt;
  logic              pipe_ld;
  logic              drive_sel;
  logic              drive_on;

  always_comb begin
    pipe_ld       = rd_q;
    pipe_vld_nxt  = rd_q;
    pipe_data_nxt = pipe_ld ? rd_data : pipe_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_vld <= 1'b0;
    else        pipe_vld <= pipe_vld_nxt;
  end

  always_ff @(posedge clk) begin
    if (pipe_ld) pipe_data <= pipe_data_nxt;
  end

  always_comb begin
    drive_sel = ft_n ? pipe_vld : rd_q;
    drive_on  = drive_sel & ~zz_q & ~wr_any;
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    if (i < USED_LANES) begin : g_used
      assign dq_oe[i] = drive_on;
      assign dq_o[i*LANE_W +: LANE_W] =
        ft_n ? pipe_data[i*LANE_W +: LANE_W] : rd_data[i*LANE_W +: LANE_W];
    end else begin : g_absent
      assign dq_oe[i] = 1'b0;
      assign dq_o[i*LANE_W +: LANE_W] = '0;
    end
  end

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int LANE_W     = 9,
  parameter int NUM_LANES  = 4,
  parameter int USED_LANES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        gw_n,
  input  logic                        bw_n,
  input  logic [NUM_LANES-1:0]        be_n,
  input  logic                        ft_n,
  input  logic                        zz,
  input  logic [LANE_W*NUM_LANES-1:0] rd_data,
  output logic [NUM_LANES-1:0]        wr_stb,
  output logic                        rd_en,
  output logic [LANE_W*NUM_LANES-1:0] dq_o,
  output logic [NUM_LANES-1:0]        dq_oe
);

  op_e                  dec_op;
  logic [NUM_LANES-1:0] dec_strb;
  logic [NUM_LANES-1:0] wr_q;
  logic                 rd_q;
  logic                 zz_q;

  sram_ctl_decode #(
    .NUM_LANES (NUM_LANES),
    .USED_LANES(USED_LANES)
  ) u_decode (
    .gw_n (gw_n),
    .bw_n (bw_n),
    .be_n (be_n),
    .zz   (zz),
    .op   (dec_op),
    .strb (dec_strb)
  );

  sram_ctl_cmd_reg #(
    .NUM_LANES(NUM_LANES)
  ) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_d   (dec_op),
    .strb_d (dec_strb),
    .zz_d   (zz),
    .wr_q   (wr_q),
    .rd_q   (rd_q),
    .zz_q   (zz_q)
  );

  sram_ctl_out_stage #(
    .LANE_W    (LANE_W),
    .NUM_LANES (NUM_LANES),
    .USED_LANES(USED_LANES)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .ft_n    (ft_n),
    .rd_q    (rd_q),
    .wr_any  (|wr_q),
    .zz_q    (zz_q),
    .rd_data (rd_data),
    .dq_o    (dq_o),
    .dq_oe   (dq_oe)
  );

  assign wr_stb = wr_q;
  assign rd_en  = rd_q;

endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
  parameter int NUM_LANES  = 4,
  parameter int USED_LANES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 gw_n,
  input logic                 bw_n,
  input logic [NUM_LANES-1:0] be_n,
  input logic                 ft_n,
  input logic                 zz,
  input logic [NUM_LANES-1:0] wr_stb,
  input logic                 rd_en,
  input logic [NUM_LANES-1:0] dq_oe
);

  localparam logic [NUM_LANES-1:0] USED_MASK =
    NUM_LANES'((64'd1 << USED_LANES) - 64'd1);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_global_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!gw_n && !zz) |=> (wr_stb == USED_MASK));

  p_byte_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && !bw_n && !zz && ((~be_n & USED_MASK) != '0))
      |=> (wr_stb == $past(~be_n & USED_MASK)));

  p_read_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && !zz && (bw_n || ((~be_n & USED_MASK) == '0)))
      |=> (rd_en && wr_stb == '0));

  p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (wr_stb == '0));

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_stb) && gw_n && bw_n) |=> (wr_stb == '0));

  p_flow_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ft_n |-> ((|dq_oe) == rd_en));

  p_pipe_oe_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ((|dq_oe) && ft_n && $past(ft_n)) |-> $past(rd_en));

  p_oe_uniform_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == '0) || (dq_oe == USED_MASK));

  p_wr_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_stb) |-> (dq_oe == '0));

  p_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> (wr_stb == '0 && !rd_en && dq_oe == '0));

  p_absent_lanes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_stb | dq_oe) & ~USED_MASK) == '0);

  always_comb begin
    if (!rst_n) begin
      a_reset_r11: assert (wr_stb == '0 && !rd_en && dq_oe == '0);
    end
  end

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(
  .NUM_LANES (NUM_LANES),
  .USED_LANES(USED_LANES)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .gw_n   (gw_n),
  .bw_n   (bw_n),
  .be_n   (be_n),
  .ft_n   (ft_n),
  .zz     (zz),
  .wr_stb (wr_stb),
  .rd_en  (rd_en),
  .dq_oe  (dq_oe)
);

// File: tb/tb_sram_port_ctrl.sv
`timescale 1ns/1ps
module tb_sram_port_ctrl;

  localparam int LW = 9;
  localparam int NL = 4;
  localparam int DW = LW * NL;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          gw_n, bw_n, ft_n, zz;
  logic [NL-1:0] be_n;
  logic [DW-1:0] rd_data;

  logic [NL-1:0] wr0, wr1, oe0, oe1;
  logic          rd0, rd1;
  logic [DW-1:0] dq0, dq1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sram_port_ctrl #(.LANE_W(LW), .NUM_LANES(NL), .USED_LANES(4)) dut (
    .clk(clk), .rst_n(rst_n), .gw_n(gw_n), .bw_n(bw_n), .be_n(be_n),
    .ft_n(ft_n), .zz(zz), .rd_data(rd_data),
    .wr_stb(wr0), .rd_en(rd0), .dq_o(dq0), .dq_oe(oe0));

  sram_port_ctrl #(.LANE_W(LW), .NUM_LANES(NL), .USED_LANES(2)) dut_n (
    .clk(clk), .rst_n(rst_n), .gw_n(gw_n), .bw_n(bw_n), .be_n(be_n),
    .ft_n(ft_n), .zz(zz), .rd_data(rd_data),
    .wr_stb(wr1), .rd_en(rd1), .dq_o(dq1), .dq_oe(oe1));

  // bench model, index 0 = full width, 1 = two-lane instance
  logic [NL-1:0] mask [2];
  logic [NL-1:0] m_wr [2];
  logic          m_rd [2];
  logic          m_zz [2];
  logic          m_pv [2];
  logic [DW-1:0] m_pd [2];
  logic          p_gw, p_zz;

  function automatic logic [NL-1:0] exp_strb(input logic g, input logic b,
      input logic [NL-1:0] e, input logic z, input logic [NL-1:0] m);
    if (z)  return '0;
    if (!g) return m;
    if (!b) return ~e & m;
    return '0;
  endfunction

  function automatic logic exp_rd(input logic g, input logic b,
      input logic [NL-1:0] e, input logic z, input logic [NL-1:0] m);
    return !z && g && (b || ((~e & m) == '0));
  endfunction

  function automatic logic [DW-1:0] lane_bits(input logic [NL-1:0] l);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < NL; i++) if (l[i]) r[i*LW +: LW] = '1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    for (int k = 0; k < 2; k++) begin
      logic [NL-1:0] aw, ao, eo;
      logic          ar;
      logic [DW-1:0] ad, ed, bm;
      string         ts, to;
      aw = (k == 0) ? wr0 : wr1;
      ao = (k == 0) ? oe0 : oe1;
      ar = (k == 0) ? rd0 : rd1;
      ad = (k == 0) ? dq0 : dq1;
      ts = (k == 1) ? "R10 strobes" : p_zz ? "R9 strobes" :
           !p_gw ? "R1 strobes" : "R2 strobes";
      chk(ts, {{(DW-NL){1'b0}}, aw}, {{(DW-NL){1'b0}}, m_wr[k]});
      chk((k == 1) ? "R10 read" : "R3 read", {{(DW-1){1'b0}}, ar},
          {{(DW-1){1'b0}}, m_rd[k]});
      eo = (((ft_n ? m_pv[k] : m_rd[k]) && !m_zz[k] && (m_wr[k] == '0))
            ? mask[k] : '0);
      to = (m_wr[k] != '0) ? "R8 oe" : m_zz[k] ? "R9 oe" :
           ft_n ? "R6 oe" : "R5 oe";
      chk(to, {{(DW-NL){1'b0}}, ao}, {{(DW-NL){1'b0}}, eo});
      bm = lane_bits(eo);
      ed = ft_n ? m_pd[k] : rd_data;
      chk(ft_n ? "R6 data" : "R5 data", ad & bm, ed & bm);
    end
  endtask

  task automatic cycle(input logic g, input logic b, input logic [NL-1:0] e,
                       input logic z);
    gw_n = g; bw_n = b; be_n = e; zz = z;
    @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++) begin
      if (m_rd[k]) m_pd[k] = rd_data;
      m_pv[k] = m_rd[k];
      m_wr[k] = exp_strb(g, b, e, z, mask[k]);
      m_rd[k] = exp_rd(g, b, e, z, mask[k]);
      m_zz[k] = z;
    end
    p_gw = g; p_zz = z;
    rd_data = {$urandom, $urandom};
    #1;
    check_all();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    mask[0] = 4'hF; mask[1] = 4'h3;
    for (int k = 0; k < 2; k++) begin
      m_wr[k] = '0; m_rd[k] = 1'b0; m_zz[k] = 1'b0; m_pv[k] = 1'b0; m_pd[k] = '0;
    end
    p_gw = 1'b1; p_zz = 1'b0;
    rst_n = 1'b0; gw_n = 1'b0; bw_n = 1'b0; be_n = '0; ft_n = 1'b0; zz = 1'b0;
    rd_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset strobes", {{(DW-NL){1'b0}}, wr0 | wr1}, '0);
    chk("R11 reset read", {{(DW-1){1'b0}}, rd0 | rd1}, '0);
    chk("R11 reset oe", {{(DW-NL){1'b0}}, oe0 | oe1}, '0);
    gw_n = 1'b1; bw_n = 1'b1; be_n = '1;
    @(negedge clk);
    rst_n = 1'b1;

    // flow-through directed
    cycle(1'b0, 1'b0, 4'b1010, 1'b0);      // R1 all lanes despite enables
    cycle(1'b1, 1'b0, 4'b0101, 1'b0);      // R2 lanes 1 and 3
    cycle(1'b1, 1'b1, 4'b1111, 1'b0);      // R4 write then read
    chk("R4 pulse", {{(DW-NL){1'b0}}, wr0}, '0);
    cycle(1'b1, 1'b1, 4'b0000, 1'b0);      // R7 read with all enables low
    chk("R7 all lanes", {{(DW-NL){1'b0}}, oe0}, {{(DW-NL){1'b0}}, 4'hF});
    cycle(1'b1, 1'b0, 4'b0011, 1'b0);      // R10 upper enables only
    chk("R10 narrow read", {{(DW-1){1'b0}}, rd1}, {{(DW-1){1'b0}}, 1'b1});
    chk("R10 full write", {{(DW-NL){1'b0}}, wr0}, {{(DW-NL){1'b0}}, 4'b1100});
    cycle(1'b0, 1'b1, 4'b1111, 1'b1);      // R9 standby masks write
    chk("R9 standby", {{(DW-NL){1'b0}}, wr0 | oe0}, '0);

    // pipelined directed
    ft_n = 1'b1;
    cycle(1'b1, 1'b1, 4'b1111, 1'b0);      // read
    cycle(1'b1, 1'b1, 4'b1111, 1'b0);      // R6 first pipelined data
    chk("R6 lag", {{(DW-NL){1'b0}}, oe0}, {{(DW-NL){1'b0}}, 4'hF});
    cycle(1'b1, 1'b0, 4'b1110, 1'b0);      // R8 write after read
    chk("R8 hiz", {{(DW-NL){1'b0}}, oe0}, '0);
    cycle(1'b1, 1'b1, 4'b1111, 1'b1);      // standby in pipeline
    cycle(1'b1, 1'b1, 4'b1111, 1'b0);

    // random in both modes
    for (int ph = 0; ph < 2; ph++) begin
      ft_n = ph[0];
      for (int n = 0; n < 2000; n++) begin
        cycle(($urandom % 8) != 0, ($urandom % 2) != 0,
              NL'($urandom), ($urandom % 16) == 0);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule